// File: doc/BRIEF.md
# Watchdog Supervisor with Dual Timeout

This block supervises a processor through a single toggle line. The software running on the processor must change the level of `wd_in` regularly. When no rising or falling edge arrives within the timeout in force, the block pulls `rst_n_out` low for a fixed pulse width. It also drops the `fault_n` flag, which stays low until software shows signs of life again. A separate low-line input stands in for a supply comparator. It forces a reset of its own and clears the fault flag.

All timing comes from a slow tick, nominally 10.24 kHz, that reaches the block as a one-cycle enable `tick_en` in the fast clock domain. Two timeout lengths are available: a long one of about 1.6 s (16384 ticks) and a short one of about 100 ms (1024 ticks). The reset pulse lasts about 50 ms (512 ticks). After every reset the long timeout is forced, which gives the software time to start up. The short period selected by `short_sel` takes over only once the first transition arrives after the release. Setting `wd_disable` stands in for leaving the watchdog pin floating and switches off the timeout altogether.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high and after it falls, `rst_n_out` is low and `fault_n` is high. `rst_n_out` stays low for exactly PULSE_TICKS ticks, counted from the first clock with `rst` low.
- R2: If `wd_in` never changes, `rst_n_out` stays high for LONG_TICKS ticks after each release and then goes low for PULSE_TICKS ticks, and this repeats.
- R3: `fault_n` goes low in the same cycle that a timeout pulls `rst_n_out` low. It stays low through the pulse and after the release. It returns high only after a `wd_in` transition that arrives while `rst_n_out` is high.
- R4: Every rising or falling edge on `wd_in` clears the watchdog count. A transition reaches the count three clocks after it appears on the pin: two synchronizer flops, then the edge register. Edges spaced closer than the timeout prevent any reset.
- R5: After any release of `rst_n_out`, the timeout is LONG_TICKS even when `short_sel` is 1. After the first transition that follows the release, with `short_sel` = 1, the next timeout ends SHORT_TICKS ticks after that edge reaches the count.
- R6: Transitions on `wd_in` while `rst_n_out` is low are ignored. They do not lengthen the pulse, do not raise `fault_n`, and do not enable the short timeout.
- R7: While `low_line` is 1, `rst_n_out` is low and `fault_n` is high from the next clock on. Once `low_line` is seen clear, `rst_n_out` stays low for PULSE_TICKS more ticks. Then the long timeout restarts from zero.
- R8: While `wd_disable` is 1, no watchdog timeout occurs. After it clears, the count starts from zero.
- R9: All counters advance only on clocks where `tick_en` is 1. With `tick_en` held at 0, neither a pending timeout nor a running reset pulse makes progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_en | input | 1 | Time-base enable, one clock wide per tick |
| wd_in | input | 1 | Toggle line from the processor (asynchronous) |
| wd_disable | input | 1 | Switches the watchdog timeout off |
| short_sel | input | 1 | 1 selects the short timeout once it is allowed |
| low_line | input | 1 | Supply-low indication, synchronous, active high |
| rst_n_out | output | 1 | Active-low reset to the processor |
| fault_n | output | 1 | Active-low watchdog fault flag |

## Verification
The watchdog is driven with a line that never moves, a line toggled just inside the long timeout, a single toggle right after a release with the short period selected, and toggles made during the reset pulse. The still line and the regular toggles show that the count is cleared on both edge directions. The single toggle measures the short timeout and shows that the long one returns after the next pulse. The toggles made during reset must change neither the pulse width, the fault flag nor the timeout length. Low-line hold, disable and frozen ticks are each measured against exact tick counts, so that off-by-one errors in the counters show up.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_HOLD  = 2'd1,
        PS_PULSE = 2'd2
    } pulse_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } wd_edge_t;

    typedef struct packed {
        logic expired;
        logic long_forced;
    } wd_timer_t;

    function automatic logic any_edge(input wd_edge_t e);
        return e.rise | e.fall;
    endfunction

    function automatic int cnt_bits(input int max_value);
        return (max_value < 2) ? 1 : $clog2(max_value + 1);
    endfunction

endpackage

// File: rtl/wdog_sync_edge.sv
module wdog_sync_edge
    import wdog_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output wd_edge_t edge_o
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], din};
        end
    end

    always_comb begin
        edge_o.rise = sh[STAGES-1] & ~sh[STAGES];
        edge_o.fall = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int LONG_TICKS  = 16384,
    parameter int SHORT_TICKS = 1024
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      hold,
    input  logic      off,
    input  logic      short_sel,
    input  logic      kick,
    output wd_timer_t stat
);
    localparam int CW = cnt_bits(LONG_TICKS);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          long_forced;
    logic [CW-1:0] last;
    logic          expired;

    always_comb begin
        last    = (short_sel && !long_forced) ? SHORT_LAST : LONG_LAST;
        expired = !hold && !off && !kick && tick && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt         <= '0;
            long_forced <= 1'b1;
        end else if (kick) begin
            cnt         <= '0;
            long_forced <= 1'b0;
        end else if (off || expired) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        stat.expired     = expired;
        stat.long_forced = long_forced;
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int PULSE_TICKS = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic low_line,
    input  logic trigger,
    output logic active
);
    localparam int PW = cnt_bits(PULSE_TICKS);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);

    pulse_state_t  st;
    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PS_PULSE;
            cnt <= '0;
        end else begin
            unique case (st)
                PS_RUN: begin
                    if (low_line) begin
                        st <= PS_HOLD;
                    end else if (trigger) begin
                        st  <= PS_PULSE;
                        cnt <= '0;
                    end
                end
                PS_HOLD: begin
                    if (!low_line) begin
                        st  <= PS_PULSE;
                        cnt <= '0;
                    end
                end
                PS_PULSE: begin
                    if (low_line) begin
                        st <= PS_HOLD;
                    end else if (tick) begin
                        if (cnt == PULSE_LAST) begin
                            st <= PS_RUN;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= PS_PULSE;
            endcase
        end
    end

    assign active = (st != PS_RUN);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int LONG_TICKS  = 16384,
    parameter int SHORT_TICKS = 1024,
    parameter int PULSE_TICKS = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic wd_in,
    input  logic wd_disable,
    input  logic short_sel,
    input  logic low_line,
    output logic rst_n_out,
    output logic fault_n
);
    wd_edge_t  wd_edge;
    wd_timer_t tstat;
    logic      in_reset;
    logic      kick;
    logic      fault_q;

    wdog_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (wd_in),
        .edge_o (wd_edge)
    );

    // edges seen while reset is driven are dropped here
    assign kick = any_edge(wd_edge) & ~in_reset;

    wdog_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .hold      (in_reset),
        .off       (wd_disable),
        .short_sel (short_sel),
        .kick      (kick),
        .stat      (tstat)
    );

    wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .low_line (low_line),
        .trigger  (tstat.expired),
        .active   (in_reset)
    );

    always_ff @(posedge clk) begin
        if (rst || low_line) begin
            fault_q <= 1'b1;
        end else if (tstat.expired) begin
            fault_q <= 1'b0;
        end else if (kick) begin
            fault_q <= 1'b1;
        end
    end

    assign rst_n_out = ~in_reset;
    assign fault_n   = fault_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic wd_in,
    input logic wd_disable,
    input logic short_sel,
    input logic low_line,
    input logic rst_n_out,
    input logic fault_n
);
    a_r1_reset_start: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rst_n_out && fault_n));

    a_r3_fault_with_timeout: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> $fell(rst_n_out));

    a_r6_fault_kept_in_reset: assert property (@(posedge clk) disable iff (rst)
        (!rst_n_out && !fault_n && !low_line) |=> !fault_n);

    a_r7_lowline_reset: assert property (@(posedge clk) disable iff (rst)
        low_line |=> (!rst_n_out && fault_n));

    a_r8_disable_no_timeout: assert property (@(posedge clk) disable iff (rst)
        (wd_disable && rst_n_out && !low_line) |=> rst_n_out);

    a_r9_no_tick_no_timeout: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && rst_n_out && !low_line) |=> rst_n_out);

    a_r9_no_tick_pulse_held: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !rst_n_out) |=> !rst_n_out);
endmodule

bind wdog_supervisor wdog_checker u_wdog_checker (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .wd_in      (wd_in),
    .wd_disable (wd_disable),
    .short_sel  (short_sel),
    .low_line   (low_line),
    .rst_n_out  (rst_n_out),
    .fault_n    (fault_n)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
    localparam int LONG  = 40;
    localparam int SHORT = 12;
    localparam int PULSE = 6;
    localparam int SYNC_LAT = 3;  // pin to counter clear, in clocks
    localparam int LIMIT = 5000;

    logic clk = 1'b0;
    logic rst, tick_en, wd_in, wd_disable, short_sel, low_line;
    logic rst_n_out, fault_n;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    wdog_supervisor #(
        .LONG_TICKS  (LONG),
        .SHORT_TICKS (SHORT),
        .PULSE_TICKS (PULSE)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .wd_in      (wd_in),
        .wd_disable (wd_disable),
        .short_sel  (short_sel),
        .low_line   (low_line),
        .rst_n_out  (rst_n_out),
        .fault_n    (fault_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (rst_n_out !== 1'b1 && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (rst_n_out !== 1'b0 && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_power();
        int n;
        short_sel = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rst_n_out == 1'b0 && fault_n == 1'b1, "R1 reset state", {rst_n_out, fault_n}, 2'b01);
        count_low(n);
        chk(n == PULSE, "R1 power-on pulse width", n, PULSE);
        count_high(n);
        chk(n == LONG, "R5 long timeout forced after start", n, LONG);
        chk(fault_n == 1'b0, "R3 fault low at timeout", fault_n, 0);
        count_low(n);
        chk(n == PULSE, "R2 timeout pulse width", n, PULSE);
        chk(fault_n == 1'b0, "R3 fault held after release", fault_n, 0);
        count_high(n);
        chk(n == LONG, "R2 repeat period with still input", n, LONG);
    endtask

    task automatic t_kick();
        int n;
        int lows = 0;
        short_sel = 1'b0;
        count_low(n);
        wd_in = ~wd_in;
        repeat (SYNC_LAT + 1) @(negedge clk);
        chk(fault_n == 1'b1, "R3 fault restored by transition", fault_n, 1);
        for (int i = 0; i < 6; i++) begin
            repeat (LONG - 6) begin
                @(negedge clk);
                if (rst_n_out == 1'b0) lows++;
            end
            wd_in = ~wd_in;
        end
        chk(lows == 0, "R4 regular toggles prevent reset", lows, 0);
        count_high(n);
        chk(n == LONG + SYNC_LAT, "R4 count restarts at last edge", n, LONG + SYNC_LAT);
    endtask

    task automatic t_ignore();
        int n;
        short_sel = 1'b1;
        @(negedge clk);
        wd_in = ~wd_in;
        @(negedge clk);
        wd_in = ~wd_in;
        count_low(n);
        chk(n + 2 == PULSE, "R6 pulse not lengthened by toggles", n + 2, PULSE);
        chk(fault_n == 1'b0, "R6 fault not raised by toggles in reset", fault_n, 0);
        count_high(n);
        chk(n == LONG, "R6 short period not enabled by toggles in reset", n, LONG);
    endtask

    task automatic t_short();
        int n;
        count_low(n);
        wd_in = ~wd_in;
        count_high(n);
        chk(n == SHORT + SYNC_LAT, "R5 short timeout after first edge", n, SHORT + SYNC_LAT);
        count_low(n);
        count_high(n);
        chk(n == LONG, "R5 long timeout forced again", n, LONG);
    endtask

    task automatic t_lowline();
        int n;
        int lows = 0;
        count_low(n);
        repeat (5) @(negedge clk);
        chk(fault_n == 1'b0, "R7 fault low before low-line", fault_n, 0);
        low_line = 1'b1;
        @(negedge clk);
        chk(rst_n_out == 1'b0 && fault_n == 1'b1, "R7 low-line resets and raises fault",
            {rst_n_out, fault_n}, 2'b01);
        repeat (30) begin
            @(negedge clk);
            if (rst_n_out == 1'b0) lows++;
        end
        chk(lows == 30, "R7 reset held while low-line active", lows, 30);
        low_line = 1'b0;
        @(negedge clk);
        count_low(n);
        chk(n == PULSE, "R7 pulse after low-line clears", n, PULSE);
        count_high(n);
        chk(n == LONG, "R7 watchdog restarts from zero", n, LONG);
    endtask

    task automatic t_disable();
        int n;
        int lows = 0;
        count_low(n);
        wd_disable = 1'b1;
        repeat (3 * LONG) begin
            @(negedge clk);
            if (rst_n_out == 1'b0) lows++;
        end
        chk(lows == 0, "R8 no timeout while disabled", lows, 0);
        wd_disable = 1'b0;
        count_high(n);
        chk(n == LONG, "R8 count from zero after enable", n, LONG);
    endtask

    task automatic t_tick();
        int n;
        int bad = 0;
        tick_en = 1'b0;
        repeat (50) begin
            @(negedge clk);
            if (rst_n_out != 1'b0) bad++;
        end
        chk(bad == 0, "R9 pulse frozen without ticks", bad, 0);
        tick_en = 1'b1;
        count_low(n);
        chk(n == PULSE, "R9 pulse resumes where it stopped", n, PULSE);
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (rst_n_out != 1'b1) bad++;
        end
        chk(bad == 0, "R9 no timeout without ticks", bad, 0);
        tick_en = 1'b1;
        count_high(n);
        chk(n == LONG - 10, "R9 timeout count resumes", n, LONG - 10);
    endtask

    initial begin
        rst = 1'b1;
        tick_en = 1'b1;
        wd_in = 1'b0;
        wd_disable = 1'b0;
        short_sel = 1'b0;
        low_line = 1'b0;
        repeat (3) @(negedge clk);
        fork
            begin
                t_power();
                t_kick();
                t_ignore();
                t_short();
                t_lowline();
                t_disable();
                t_tick();
            end
            begin
                repeat (100000) @(negedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule